// File: doc/BRIEF.md
# TDM Timeslot Channel Demultiplexer

This block sits at the receive end of a serial time-division highway. Every bit on the highway belongs to one 8-bit timeslot, and each timeslot feeds its own downstream HDLC receiver. The block counts bits from an active-high frame sync. It passes the serial bit straight through and raises exactly one bit of a per-channel enable vector, so that only the receiver that owns the current timeslot samples that bit.

Two sync conventions are available, and a parameter picks one at build time.

- **Coincident mode:** the sync pulse arrives together with the final data bit of the frame. The frame is then `8*NUM_CH` bits long.
- **Framing-bit mode:** the sync pulse marks an extra bit that carries no channel data. The frame is then `8*NUM_CH+1` bits long.

In both modes the bit that follows the sync cycle is bit 0 of timeslot 0. After reset, the block stays silent until it has seen a sync pulse. If the highway runs past the last configured timeslot without a new sync, all enables stay low.

Top module: `tdm_slot_demux`

## Requirements
- R1: While `rst` is high, and from reset until the first cycle in which `frame_sync` is high, `ch_en` is all zeros. This includes that first sync cycle.
- R2: `bit_out` equals `ser_data` in every cycle.
- R3: Once aligned, each channel's enable stays high for 8 consecutive bits. Channel n is followed by channel n+1 (bit n of `ch_en` is channel n).
- R4: The bit in the cycle right after a sync cycle belongs to channel 0 (`ch_en` == 1), provided sync is not high again in that cycle.
- R5: At most one bit of `ch_en` is high in any cycle.
- R6: In coincident mode (`SEP_SYNC`=0), the enable during a sync cycle is that of the bit's position in the frame. In a frame of exactly `8*NUM_CH` bits, that is channel `NUM_CH-1`.
- R7: In framing-bit mode (`SEP_SYNC`=1), `ch_en` is all zeros in every sync cycle. A frame is `8*NUM_CH+1` bits long.
- R8: When more than `8*NUM_CH` bits have passed since the last sync, `ch_en` is all zeros until the next sync. The count does not wrap.
- R9: A sync arriving at any bit position, including mid-timeslot, realigns the count at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Active-high reset, asynchronous |
| ser_data | input | 1 | Serial highway data |
| frame_sync | input | 1 | Active-high frame sync |
| bit_out | output | 1 | Serial data passed through |
| ch_en | output | NUM_CH | One-hot channel bit enable, bit n for timeslot n |

## Verification
Some rules are checked by assertions on every cycle:
- the enable never has more than one bit set;
- the slot after a sync is channel 0;
- in framing-bit mode, sync cycles are silent;
- the enable only holds, steps to the next channel or drops to zero;
- reset forces silence.

Other behaviour can only be shown by the bench's scenarios, which follow the stream over whole frames:
- the exact 8-bit slot width;
- the coincident-mode enable during the sync bit;
- silence before the first sync;
- the non-wrapping overrun after a missing sync;
- realignment by a sync that arrives mid-slot.

// File: rtl/tdm_slot_demux.sv
module tdm_slot_demux #(
  parameter int NUM_CH   = 4,
  parameter bit SEP_SYNC = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data,
  input  logic              frame_sync,
  output logic              bit_out,
  output logic [NUM_CH-1:0] ch_en
);
  localparam int CW = $clog2(NUM_CH) + 1;
  localparam logic [CW-1:0] CH_TOP = '1;

  logic [2:0]    bit_idx;
  logic [CW-1:0] slot_idx;
  logic          aligned;
  logic          mute;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bit_idx  <= '0;
      slot_idx <= '0;
      aligned  <= 1'b0;
    end else if (frame_sync) begin
      bit_idx  <= '0;
      slot_idx <= '0;
      aligned  <= 1'b1;
    end else begin
      bit_idx <= bit_idx + 3'd1;
      if (bit_idx == 3'd7 && slot_idx != CH_TOP)
        slot_idx <= slot_idx + 1'b1;
    end
  end

  assign mute    = !aligned || (SEP_SYNC && frame_sync);
  assign bit_out = ser_data;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign ch_en[i] = !mute && (slot_idx == CW'(i));
  end
endmodule

// File: rtl/tdm_slot_demux_chk.sv
module tdm_slot_demux_chk #(
  parameter int NUM_CH   = 4,
  parameter bit SEP_SYNC = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_data,
  input logic              frame_sync,
  input logic              bit_out,
  input logic [NUM_CH-1:0] ch_en
);
  AST_RESET_SILENT: assert property (@(posedge clk) rst |-> ch_en == '0); // R1
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst) $onehot0(ch_en)); // R5
  AST_SLOT0_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> (frame_sync || ch_en == NUM_CH'(1))); // R4
  AST_FRAMING_BIT_MUTE: assert property (@(posedge clk) disable iff (rst)
    (SEP_SYNC && frame_sync) |-> ch_en == '0); // R7
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
    (ch_en != '0 && !frame_sync) |=> (frame_sync || ch_en == '0 ||
      ch_en == $past(ch_en) || ch_en == ($past(ch_en) << 1))); // R3
endmodule

bind tdm_slot_demux tdm_slot_demux_chk #(.NUM_CH(NUM_CH), .SEP_SYNC(SEP_SYNC)) chk_i (.*);

// File: tb/tdm_slot_demux_tb_top.sv
`timescale 1ns/1ps
module tdm_slot_demux_tb_top;
  localparam int N = 4;
  localparam int FR = 8 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_data = 1'b0;
  logic frame_sync = 1'b0;
  logic bo_a, bo_b;
  logic [N-1:0] en_a, en_b;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  bit lk = 1'b0;
  int pos = 0;
  string phase_tag = "R3";

  always #2 clk = ~clk;

  tdm_slot_demux #(.NUM_CH(N), .SEP_SYNC(1'b0)) dut_i (
    .clk(clk), .rst(rst), .ser_data(ser_data), .frame_sync(frame_sync),
    .bit_out(bo_a), .ch_en(en_a));

  tdm_slot_demux #(.NUM_CH(N), .SEP_SYNC(1'b1)) dut_b_i (
    .clk(clk), .rst(rst), .ser_data(ser_data), .frame_sync(frame_sync),
    .bit_out(bo_b), .ch_en(en_b));

  function automatic logic [N-1:0] exp_en(bit sep, bit r, bit l, int p, bit s);
    int slot;
    if (r || !l) return '0;
    if (sep && s) return '0;
    slot = p / 8;
    if (slot >= N) return '0;
    return N'(1) << slot;
  endfunction

  function automatic string tag_of(bit sep, bit r, bit l, int p, bit s);
    if (r || !l) return "R1";
    if (s && sep) return "R7";
    if (s) return "R6";
    if (p / 8 >= N) return "R8";
    if (p == 0) return "R4";
    return phase_tag;
  endfunction

  task automatic check_en(logic [N-1:0] got, logic [N-1:0] exp, string tag, string who);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: ch_en actual %b expected %b (pos %0d)", tag, who, got, exp, pos);
    end
  endtask

  task automatic check_bit(logic got, logic exp, string tag);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(bit s, bit d);
    frame_sync = s;
    ser_data = d;
    #1;
    check_en(en_a, exp_en(1'b0, rst, lk, pos, s), tag_of(1'b0, rst, lk, pos, s), "coincident");
    check_en(en_b, exp_en(1'b1, rst, lk, pos, s), tag_of(1'b1, rst, lk, pos, s), "framing-bit");
    check_bit(bo_a, d, "R2");
    check_bit(bo_b, d, "R2");
    check_bit(1'b1, ($countones(en_a) <= 1) && ($countones(en_b) <= 1), "R5");
    @(posedge clk);
    if (rst) begin
      lk = 1'b0;
      pos = 0;
    end else if (s) begin
      lk = 1'b1;
      pos = 0;
    end else if (pos < 100000) begin
      pos++;
    end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: during reset and before the first sync
    for (int i = 0; i < 4; i++) step(1'b0, 1'(i));
    rst = 1'b0;
    for (int i = 0; i < 12; i++) step(1'b0, 1'($urandom));
    // R6, R3, R4: coincident framing, sync with the last bit
    for (int k = 0; k < FR * 10; k++) step(k % FR == FR - 1, 1'($urandom));
    // R7: framing-bit convention
    for (int k = 0; k < (FR + 1) * 10; k++) step(k % (FR + 1) == 0, 1'($urandom));
    // R8: missing sync, no wrap
    for (int k = 0; k < 150; k++) step(1'b0, 1'($urandom));
    // R9: syncs at random positions
    phase_tag = "R9";
    for (int k = 0; k < 3000; k++) step(($urandom % 23) == 0, 1'($urandom));
    // R1: reset again mid-stream
    phase_tag = "R3";
    rst = 1'b1;
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1);
    // R9: two back-to-back syncs, then a sync in the middle of a slot
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 13; i++) step(1'b0, 1'($urandom));
    step(1'b1, 1'b0);
    for (int i = 0; i < FR + 20; i++) step(1'b0, 1'($urandom));
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule